// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block lives on the processor side of a simple 16-bit bus. It runs the read cycles that acknowledge an interrupt, and the read cycles that announce the return from one. A one-cycle request names the kind of sequence (non-maskable, non-vectored, vectored, or vectored through a cascaded secondary controller) and whether it is an acknowledge or a return. The block then places an address, a 4-bit status code, an active-low read strobe, a high-byte enable and the A0 bit on the bus. It holds them until the responder signals ready, and ends with a one-cycle completion pulse that carries the 8-bit vector.

Cascaded sequences chain two dependent reads. The first read returns a negative cascade index between -16 and -1. That index, plus 16, selects an entry in a 16-entry address table that is loaded through a write port. The second read goes to the selected address. Bit 0 of that address chooses which byte lane of the data bus carries the vector. A first read with a clear sign bit is a protocol error: the sequence stops there and the error flag is raised.

Top module: `intack_seq`

## Requirements
- R1: After reset, bus_req and busy are low, bus_rd_n is high, and done and err are low.
- R2: A non-maskable acknowledge is one read at address FFFF00 hex with status 0100, high-byte enable high and A0 low. The returned data is ignored and the vector reported is 0.
- R3: A non-vectored acknowledge is one read at FFFE00 hex with status 0100, high-byte enable high and A0 low. It reports vector 0.
- R4: A return request for a non-maskable or non-vectored interrupt raises done on the next cycle and never asserts bus_req.
- R5: A vectored acknowledge is one read at FFFE00 hex with status 0100 and reports data bits 7:0 as the vector. A vectored return is one read at FFFE00 hex with status 0110 and reports data bits 7:0.
- R6: A cascaded acknowledge first reads FFFE00 hex with status 0100. Bits 3:0 of that data (the index plus 16) select a table entry, and a second read with status 0101 goes to that entry's address.
- R7: In the second cascaded read, an even address drives high-byte enable high and A0 low and takes the vector from data bits 7:0. An odd address drives high-byte enable low and A0 high and takes the vector from bits 15:8. Any value from 0 to 255 is reported unchanged.
- R8: A cascaded return first reads FFFE00 hex with status 0110, then reads the looked-up address with status 0111. Its data is ignored and vector 0 is reported.
- R9: If bit 7 of the first cascaded read is 0, done and err rise together with vector 0 and no second read is made.
- R10: Each bus cycle holds bus_req, address, status, high-byte enable and A0 unchanged until bus_ready is sampled high. done pulses for one cycle, on the cycle after the last ready edge, and bus_req is low in that cycle.
- R11: With tbl_we high at a clock edge, entry tbl_idx takes tbl_wdata. Later cascaded lookups use the new value.
- R12: req_valid is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a sequence (accepted when not busy) |
| req_kind | input | 2 | 0 non-maskable, 1 non-vectored, 2 vectored, 3 cascaded |
| req_ret | input | 1 | 0 acknowledge, 1 return |
| busy | output | 1 | Sequence in progress |
| tbl_we | input | 1 | Cascade table write enable |
| tbl_idx | input | 4 | Cascade table entry to write |
| tbl_wdata | input | 24 | Cascade address to store |
| bus_req | output | 1 | Bus cycle in progress |
| bus_addr | output | 24 | Bus address |
| bus_status | output | 4 | Cycle status code |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_hbe | output | 1 | High-byte enable |
| bus_a0 | output | 1 | Address bit 0 |
| bus_ready | input | 1 | Responder ready, ends the cycle |
| bus_data | input | 16 | Read data |
| done | output | 1 | Sequence complete pulse |
| vector | output | 8 | Vector number, valid with done |
| err | output | 1 | Protocol error, valid with done |

## Verification
The bench builds the block with its default 24-bit address and 16-entry table. The full signed index range is therefore reachable: the bench loads both extremes, -16 at entry 0 and -1 at entry 15, with even and odd addresses so that both byte lanes are exercised. The responder stalls for varying numbers of cycles, which tests how the bus outputs are held while waiting. A stray request is injected mid-sequence to test that it is ignored. Vectors at 0, 127 and 255 test the limits of the byte that is reported.

// File: rtl/intack_seq.sv
module intack_seq #(
  parameter int ADDR_W = 24,
  parameter int TBL_N  = 16,
  parameter logic [ADDR_W-1:0] NMI_ADDR = 'hFFFF00,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 'hFFFE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_ret,
  output logic              busy,
  input  logic              tbl_we,
  input  logic [3:0]        tbl_idx,
  input  logic [ADDR_W-1:0] tbl_wdata,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [3:0]        bus_status,
  output logic              bus_rd_n,
  output logic              bus_hbe,
  output logic              bus_a0,
  input  logic              bus_ready,
  input  logic [15:0]       bus_data,
  output logic              done,
  output logic [7:0]        vector,
  output logic              err
);
  localparam int IDX_W = $clog2(TBL_N);
  localparam logic [1:0] K_NMI = 2'd0, K_VEC = 2'd2, K_CASC = 2'd3;
  localparam logic [3:0] S_ACK1 = 4'b0100, S_ACK2 = 4'b0101,
                         S_RET1 = 4'b0110, S_RET2 = 4'b0111;

  typedef enum logic [1:0] {IDLE, CYC1, CYC2} st_t;
  st_t st;
  logic [1:0] kind_q;
  logic       ret_q;
  logic [ADDR_W-1:0] tbl [TBL_N];
  logic [ADDR_W-1:0] casc_addr;

  assign busy      = (st != IDLE);
  assign bus_rd_n  = ~bus_req;
  assign casc_addr = tbl[bus_data[IDX_W-1:0]];

  always_ff @(posedge clk)
    if (tbl_we) tbl[tbl_idx[IDX_W-1:0]] <= tbl_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; kind_q <= '0; ret_q <= 1'b0;
      bus_req <= 1'b0; bus_addr <= '0; bus_status <= '0;
      bus_hbe <= 1'b0; bus_a0 <= 1'b0;
      done <= 1'b0; err <= 1'b0; vector <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          kind_q <= req_kind;
          ret_q  <= req_ret;
          if (req_ret && !req_kind[1]) begin
            done <= 1'b1; vector <= '0;
          end else begin
            st <= CYC1; bus_req <= 1'b1;
            bus_addr <= (req_kind == K_NMI) ? NMI_ADDR : VEC_ADDR;
            bus_status <= req_ret ? S_RET1 : S_ACK1;
            bus_hbe <= 1'b1; bus_a0 <= 1'b0;
          end
        end
        CYC1: if (bus_ready) begin
          if (kind_q == K_CASC && bus_data[7]) begin
            st <= CYC2;
            bus_addr <= casc_addr;
            bus_status <= ret_q ? S_RET2 : S_ACK2;
            bus_hbe <= ~casc_addr[0];
            bus_a0 <= casc_addr[0];
          end else begin
            st <= IDLE; bus_req <= 1'b0; bus_addr <= '0; bus_status <= '0;
            bus_hbe <= 1'b0; bus_a0 <= 1'b0;
            done <= 1'b1;
            err <= (kind_q == K_CASC);
            vector <= (kind_q == K_VEC) ? bus_data[7:0] : 8'd0;
          end
        end
        CYC2: if (bus_ready) begin
          st <= IDLE; bus_req <= 1'b0; bus_addr <= '0; bus_status <= '0;
          bus_hbe <= 1'b0; bus_a0 <= 1'b0;
          done <= 1'b1;
          vector <= ret_q ? 8'd0 : (bus_a0 ? bus_data[15:8] : bus_data[7:0]);
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intack_seq_chk.sv
module intack_seq_chk #(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] NMI_ADDR = 'hFFFF00,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 'hFFFE00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_status,
  input logic              bus_hbe,
  input logic              bus_a0,
  input logic              busy,
  input logic              done,
  input logic              err
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_status)
                                 && $stable(bus_hbe) && $stable(bus_a0)));
  // R2
  nmi_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr == NMI_ADDR) |-> (bus_status == 4'b0100 && bus_hbe && !bus_a0));
  // R3
  vec_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr == VEC_ADDR) |-> (bus_hbe && !bus_a0));
  // R7
  casc_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && (bus_status == 4'b0101 || bus_status == 4'b0111)) |-> (bus_hbe != bus_a0));
  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);
endmodule

bind intack_seq intack_seq_chk #(.ADDR_W(ADDR_W), .NMI_ADDR(NMI_ADDR), .VEC_ADDR(VEC_ADDR)) u_chk (.*);

// File: tb/intack_seq_tb.sv
module intack_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ret = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic tbl_we = 1'b0;
  logic [3:0] tbl_idx = '0;
  logic [23:0] tbl_wdata = '0;
  logic bus_ready = 1'b0;
  logic [15:0] bus_data = 16'hA5A5;
  logic busy, bus_req, bus_rd_n, bus_hbe, bus_a0, done, err;
  logic [23:0] bus_addr;
  logic [3:0] bus_status;
  logic [7:0] vector;

  int checks = 0, failures = 0;

  intack_seq u_dut (.*);

  always #4 clk = ~clk;

  // responder
  int rq_dly[$];
  logic [15:0] rq_dat[$];
  int wcnt = -1;
  always @(negedge clk) begin
    if (bus_ready) begin
      bus_ready = 1'b0; bus_data = 16'hA5A5; wcnt = -1;
    end else if (bus_req && rq_dly.size() > 0) begin
      if (wcnt < 0) wcnt = rq_dly[0];
      if (wcnt == 0) begin
        bus_ready = 1'b1; bus_data = rq_dat.pop_front(); void'(rq_dly.pop_front());
      end else wcnt--;
    end
  end

  // behavioural reference model
  int m_phase = 0, m_kind = 0;
  bit m_ret = 0, m_req = 0, m_hbe = 0, m_a0 = 0, m_done = 0, m_err = 0;
  logic [23:0] m_addr = '0;
  logic [3:0] m_stat = '0;
  logic [7:0] m_vec = '0;
  logic [23:0] m_tbl [16];
  string m_tag = "R1";

  task automatic m_idle();
    m_phase = 0; m_req = 0; m_addr = '0; m_stat = '0; m_hbe = 0; m_a0 = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idle(); m_done = 0; m_err = 0; m_vec = '0;
    end else begin
      logic [23:0] la;
      m_done = 0; m_err = 0;
      la = m_tbl[bus_data[3:0]];
      if (m_phase == 0) begin
        if (req_valid) begin
          m_kind = req_kind; m_ret = req_ret;
          if (req_ret && req_kind < 2) begin m_done = 1; m_vec = 0; end
          else begin
            m_phase = 1; m_req = 1;
            m_addr = (req_kind == 0) ? 24'hFFFF00 : 24'hFFFE00;
            m_stat = req_ret ? 4'b0110 : 4'b0100; m_hbe = 1; m_a0 = 0;
          end
        end
      end else if (m_phase == 1) begin
        if (bus_ready) begin
          if (m_kind == 3 && bus_data[7]) begin
            m_phase = 2; m_addr = la; m_stat = m_ret ? 4'b0111 : 4'b0101;
            m_a0 = la[0]; m_hbe = !la[0];
          end else begin
            m_idle(); m_done = 1; m_err = (m_kind == 3);
            m_vec = (m_kind == 2) ? bus_data[7:0] : 8'd0;
          end
        end
      end else begin
        if (bus_ready) begin
          m_vec = m_ret ? 8'd0 : (m_a0 ? bus_data[15:8] : bus_data[7:0]);
          m_idle(); m_done = 1;
        end
      end
      if (tbl_we) m_tbl[tbl_idx] = tbl_wdata;
    end
  end

  // per-cycle comparison
  always @(negedge clk) if (rst_n) begin
    checks++;
    if ({bus_req, bus_rd_n, bus_addr, bus_status, bus_hbe, bus_a0, busy, done, err} !==
        {m_req, !m_req, m_addr, m_stat, m_hbe, m_a0, m_phase != 0, m_done, m_err}
        || (done && vector !== m_vec)) begin
      failures++;
      $display("FAIL %s cycle: actual req=%b addr=%h st=%b hbe=%b a0=%b busy=%b done=%b err=%b vec=%h expected req=%b addr=%h st=%b hbe=%b a0=%b busy=%b done=%b err=%b vec=%h",
        m_tag, bus_req, bus_addr, bus_status, bus_hbe, bus_a0, busy, done, err, vector,
        m_req, m_addr, m_stat, m_hbe, m_a0, m_phase != 0, m_done, m_err, m_vec);
    end
  end

  int done_total = 0;
  bit bus_seen = 0;
  always @(negedge clk) begin
    if (done) done_total++;
    if (bus_req) bus_seen = 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input int d, input logic [15:0] v);
    rq_dly.push_back(d); rq_dat.push_back(v);
  endtask

  task automatic run(input int kind, input bit ret, input string tag,
                     input int exp_vec, input bit exp_err, input bit inject);
    int d0;
    bit got;
    got = 0;
    m_tag = tag; bus_seen = 0; d0 = done_total;
    @(negedge clk); req_valid = 1; req_kind = kind[1:0]; req_ret = ret;
    for (int i = 0; i < 200 && !got; i++) begin
      @(negedge clk);
      req_valid = 0;
      if (inject && i == 0) begin req_valid = 1; req_kind = 2'd0; req_ret = 1; end
      if (done) begin
        got = 1;
        chk(vector == exp_vec[7:0], tag, vector, exp_vec);
        chk(err == exp_err, tag, err, exp_err);
      end
    end
    req_valid = 0;
    chk(got, tag, got, 1);
    repeat (3) @(negedge clk);
    if (inject) chk(done_total - d0 == 1, "R12", done_total - d0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(!bus_req && bus_rd_n && !busy && !done && !err, "R1",
        {bus_req, bus_rd_n, busy, done, err}, 5'b01000);
    // R11 table load: odd entries get odd addresses
    m_tag = "R11";
    for (int i = 0; i < 16; i++) begin
      tbl_we = 1; tbl_idx = i[3:0]; tbl_wdata = 24'h200000 | (24'(i) << 4) | 24'(i & 1);
      @(negedge clk);
    end
    tbl_we = 0;

    push(2, 16'h1234); run(0, 0, "R2", 0, 0, 0);
    push(0, 16'h00AA); run(1, 0, "R3", 0, 0, 0);
    push(1, 16'hFF55); run(2, 0, "R5", 8'h55, 0, 0);
    push(3, 16'h007F); run(2, 0, "R5", 8'h7F, 0, 1);
    push(0, 16'h0000); run(2, 0, "R5", 8'h00, 0, 0);
    push(2, 16'h1155); run(2, 1, "R5", 8'h55, 0, 0);
    run(0, 1, "R4", 0, 0, 0); chk(!bus_seen, "R4", bus_seen, 0);
    run(1, 1, "R4", 0, 0, 0); chk(!bus_seen, "R4", bus_seen, 0);
    // index -16 -> entry 0 (even address 200000): low lane
    push(1, 16'h00F0); push(2, 16'h12C3); run(3, 0, "R6", 8'hC3, 0, 0);
    // index -1 -> entry 15 (odd address 2000F1): high lane, vector 255
    push(0, 16'h00FF); push(1, 16'hFF07); run(3, 0, "R7", 8'hFF, 0, 1);
    // index -2 -> entry 14 even, vector 0
    push(0, 16'h00FE); push(0, 16'hFF00); run(3, 0, "R7", 8'h00, 0, 0);
    // cascaded return index -3 -> entry 13 odd
    push(1, 16'h00FD); push(1, 16'h5A5A); run(3, 1, "R8", 0, 0, 0);
    // R9 sign bit clear
    push(0, 16'h0005); run(3, 0, "R9", 0, 1, 0);
    push(2, 16'hFF70); run(3, 1, "R9", 0, 1, 0);
    // R11 rewrite entry 3 to odd address, then use it
    m_tag = "R11";
    @(negedge clk); tbl_we = 1; tbl_idx = 4'd3; tbl_wdata = 24'h3456_01 >> 4 | 24'h1;
    @(negedge clk); tbl_we = 0;
    push(0, 16'h00F3); push(0, 16'h9C11); run(3, 0, "R11", 8'h9C, 0, 0);
    // R10 long stall
    push(9, 16'h0042); run(2, 0, "R10", 8'h42, 0, 0);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule